// File: doc/BRIEF.md
# Flash Erase-Verify Command Sequencer

This block is a register-mapped controller that takes a three-write command sequence from a host bus and then scans a small memory array to find out whether every word is erased. The host first loads a clock divider. It then writes any value to the data port, which selects the target block, and writes the verify code into the command register. A write of 1 to the buffer-empty flag in the status register launches the command. The block checks the order of these writes, flags misuse through an access-error bit, and can hold one further command queued behind the one that is running.

The array is held inside the block as a register array. A test-only preload port writes individual words. A verify run takes exactly the array depth plus twelve clock cycles. At the end the command-complete flag sets, and the blank flag reports whether every word held the erased value of all ones. Only the verify code is legal. Every other code is refused as an access error.

Top module: `flash_verify_seq`

## Requirements
- R1: After reset the status register (select 2) reads 0xC0: bit 7 buffer-empty = 1, bit 6 complete = 1, bit 4 access-error = 0, bit 2 blank = 0. The divider register (select 0) reads 0x00.
- R2: Any write to the divider register (select 0) stores bits 6:0 and sets bit 7, the loaded flag, which stays set until reset.
- R3: A launch (status write with bit 7 = 1) that follows a data write (select 3) and then a command write of 0x05 (select 1) clears buffer-empty and complete on that clock edge. Buffer-empty sets again on the next edge when no other command is running.
- R4: Complete sets on the DEPTH+12th clock edge after the launch edge and stays clear before that edge.
- R5: When complete sets, blank is 1 only if every array word equals all ones. Otherwise blank is 0.
- R6: A data write while a sequence is already past its first step, or a command write not directly preceded by a data write, sets access-error and restarts the sequence.
- R7: A launch without a prior data write and command write sets access-error and starts nothing.
- R8: A data or command write while the divider loaded flag is 0 sets access-error.
- R9: A command write with any code other than 0x05 sets access-error.
- R10: While access-error is set, launches and sequence writes are ignored. Writing a status value with bit 4 = 1 clears access-error. A launch bit in that same write is still ignored.
- R11: A status write of 0x00 abandons a partly entered sequence, so a launch that follows it sets access-error.
- R12: A command launched while another is running is queued. When the running command ends, complete stays 0 and buffer-empty sets on that edge. The queued command then runs for DEPTH+12 cycles and sets complete.
- R13: Each accepted launch clears blank on the launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 divider, 1 command, 2 status, 3 data/address |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel (3 reads 0) |
| rd_data | output | 8 | Read data of the selected register |
| pre_en | input | 1 | Test preload strobe for the array |
| pre_idx | input | $clog2(DEPTH) | Preload word index |
| pre_word | input | WORD_W | Preload word value |

## Verification
Assertions check the following on every cycle:
- complete stays low while a run is active;
- a launch attempted under an access error starts nothing;
- a queued command exists only while a run is active;
- blank only rises together with complete;
- a run, once started, stays active until its final count.

The bench scenarios cover the parts that depend on a history of writes:
- the exact edge at which complete appears;
- the blank result for an erased array and for an array with one bad word;
- every access-error rule;
- the abort write;
- a second command queued behind a running one.

// File: rtl/flash_verify_seq.sv
module flash_verify_seq #(
  parameter int DEPTH       = 16,
  parameter int WORD_W      = 8,
  parameter int EXTRA       = 12,
  parameter logic [7:0] VERIFY_CODE = 8'h05
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [7:0]               wr_data,
  input  logic [1:0]               rd_sel,
  output logic [7:0]               rd_data,
  input  logic                     pre_en,
  input  logic [$clog2(DEPTH)-1:0] pre_idx,
  input  logic [WORD_W-1:0]        pre_word
);
  localparam int AW    = $clog2(DEPTH);
  localparam int TOTAL = DEPTH + EXTRA;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [6:0] div_val;
  logic       div_loaded;
  logic [7:0] cmd_reg;
  logic [1:0] step;
  logic       buf_empty, done, acc_err, blank;
  logic       busy, pend, scan_ok;
  logic [CW-1:0] cnt;

  wire wr_div = wr_en && wr_sel == 2'd0;
  wire wr_cmd = wr_en && wr_sel == 2'd1;
  wire wr_sts = wr_en && wr_sel == 2'd2;
  wire wr_dat = wr_en && wr_sel == 2'd3;

  wire gate       = div_loaded && buf_empty;
  wire bad_dat    = wr_dat && !acc_err && (!gate || step != 2'd0);
  wire bad_cmd    = wr_cmd && !acc_err && (!gate || step != 2'd1 || wr_data != VERIFY_CODE);
  wire launch_try = wr_sts && wr_data[7] && !acc_err;
  wire bad_launch = launch_try && step != 2'd2;
  wire launch_ok  = launch_try && step == 2'd2;
  wire abort      = wr_sts && wr_data == 8'h00;
  wire err_set    = bad_dat || bad_cmd || bad_launch;

  wire finish = busy && cnt == CW'(TOTAL - 1);
  wire free   = !busy || (finish && !pend);
  wire start  = launch_ok && free;
  wire queue  = launch_ok && !free;
  wire move   = finish && pend;
  wire word_erased = mem[cnt[AW-1:0]] == {WORD_W{1'b1}};

  assign rd_data = (rd_sel == 2'd0) ? {div_loaded, div_val} :
                   (rd_sel == 2'd1) ? cmd_reg :
                   (rd_sel == 2'd2) ? {buf_empty, done, 1'b0, acc_err, 1'b0, blank, 2'b00} :
                   8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_val    <= '0;
      div_loaded <= 1'b0;
      cmd_reg    <= '0;
      step       <= 2'd0;
      acc_err    <= 1'b0;
    end else begin
      if (wr_div) begin
        div_val    <= wr_data[6:0];
        div_loaded <= 1'b1;
      end
      if (wr_cmd && !acc_err && !bad_cmd) cmd_reg <= wr_data;
      if (err_set || launch_ok || abort) step <= 2'd0;
      else if (wr_dat && !acc_err)       step <= 2'd1;
      else if (wr_cmd && !acc_err)       step <= 2'd2;
      if (err_set)                      acc_err <= 1'b1;
      else if (wr_sts && wr_data[4])    acc_err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend      <= 1'b0;
      cnt       <= '0;
      scan_ok   <= 1'b1;
      buf_empty <= 1'b1;
      done      <= 1'b1;
      blank     <= 1'b0;
    end else begin
      if (start || move) busy <= 1'b1;
      else if (finish)   busy <= 1'b0;
      if (queue)     pend <= 1'b1;
      else if (move) pend <= 1'b0;
      if (start || move) cnt <= '0;
      else if (busy)     cnt <= cnt + 1'b1;
      if (start || move)                   scan_ok <= 1'b1;
      else if (busy && cnt < CW'(DEPTH))   scan_ok <= scan_ok && word_erased;
      buf_empty <= !(launch_ok || (pend && !move));
      if (launch_ok)              done <= 1'b0;
      else if (finish && !pend)   done <= 1'b1;
      if (launch_ok)              blank <= 1'b0;
      else if (finish && !pend)   blank <= scan_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= {WORD_W{1'b1}};
    end else if (pre_en) begin
      mem[pre_idx] <= pre_word;
    end
  end

  p_done_low_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  p_run_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt < CW'(TOTAL - 1)) |=> busy);
  p_err_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wr_data[7] && acc_err && !busy) |=> !busy);
  p_queue_needs_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> busy);
  p_blank_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank) |-> done);
  p_unloaded_no_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !div_loaded |-> step == 2'd0);
  p_launch_clears_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ok |=> !buf_empty && !done);
endmodule

// File: tb/flash_verify_seq_tb.sv
module flash_verify_seq_tb;
  localparam int DEPTH = 16;
  localparam int T = DEPTH + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = 2'd2;
  logic [7:0] rd_data;
  logic pre_en = 1'b0;
  logic [$clog2(DEPTH)-1:0] pre_idx = '0;
  logic [7:0] pre_word = '0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_verify_seq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pre_en(pre_en), .pre_idx(pre_idx),
    .pre_word(pre_word)
  );

  // {sel, data, expected status}
  localparam logic [17:0] VEC [15] = '{
    {2'd3, 8'h00, 8'hC0}, // R6 first data write accepted
    {2'd3, 8'h00, 8'hD0}, // R6 data twice
    {2'd2, 8'h10, 8'hC0}, // R10 clear
    {2'd1, 8'h05, 8'hD0}, // R6 command without data
    {2'd2, 8'h90, 8'hC0}, // R10 launch ignored, err cleared
    {2'd2, 8'h80, 8'hD0}, // R7 launch without sequence
    {2'd2, 8'h10, 8'hC0},
    {2'd3, 8'h00, 8'hC0},
    {2'd1, 8'h41, 8'hD0}, // R9 illegal code
    {2'd2, 8'h10, 8'hC0},
    {2'd3, 8'h00, 8'hC0},
    {2'd1, 8'h05, 8'hC0},
    {2'd2, 8'h00, 8'hC0}, // R11 abort
    {2'd2, 8'h80, 8'hD0}, // R11 launch after abort refused
    {2'd2, 8'h10, 8'hC0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic launch_seq();
    bus_wr(2'd3, 8'hA5);
    bus_wr(2'd1, 8'h05);
    bus_wr(2'd2, 8'h80);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", rd_data, 8'hC0);
    rd_sel = 2'd0; #1;
    chk("R1 divider", rd_data, 8'h00);
    rd_sel = 2'd2;

    bus_wr(2'd3, 8'h00);
    chk("R8 data unloaded", rd_data, 8'hD0);
    bus_wr(2'd2, 8'h10);
    bus_wr(2'd1, 8'h05);
    chk("R8 command unloaded", rd_data, 8'hD0);
    bus_wr(2'd2, 8'h10);

    bus_wr(2'd0, 8'h13);
    rd_sel = 2'd0; #1;
    chk("R2 divider loaded", rd_data, 8'h93);
    rd_sel = 2'd2;

    for (int i = 0; i < 15; i++) begin
      bus_wr(VEC[i][17:16], VEC[i][15:8]);
      chk($sformatf("R6/R7/R9/R10/R11 vector %0d", i), rd_data, VEC[i][7:0]);
    end

    launch_seq();
    chk("R3 launch edge", rd_data, 8'h00);
    wait_n(1);
    chk("R3 buffer free", rd_data, 8'h80);
    wait_n(T - 2);
    chk("R4 one cycle early", rd_data, 8'h80);
    wait_n(1);
    chk("R4 R5 complete blank", rd_data, 8'hC4);

    launch_seq();
    chk("R13 blank cleared", rd_data, 8'h00);
    wait_n(T);
    chk("R5 blank again", rd_data, 8'hC4);

    pre_en = 1'b1; pre_idx = 4'd9; pre_word = 8'h7F;
    @(negedge clk);
    pre_en = 1'b0;
    launch_seq();
    wait_n(T);
    chk("R5 not blank", rd_data, 8'hC0);

    pre_en = 1'b1; pre_word = 8'hFF;
    @(negedge clk);
    pre_en = 1'b0;
    launch_seq();
    wait_n(1);
    launch_seq();
    chk("R12 queued", rd_data, 8'h00);
    wait_n(T - 5);
    chk("R12 before first end", rd_data, 8'h00);
    wait_n(1);
    chk("R12 first end no complete", rd_data, 8'h80);
    wait_n(T - 1);
    chk("R12 second running", rd_data, 8'h80);
    wait_n(1);
    chk("R12 second complete", rd_data, 8'hC4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule